// File: doc/BRIEF.md
# DMA Channel Address Sequencer

This block keeps the address state for four DMA channels. Each channel has a source address, a destination address and a small control byte. The control byte picks how each address moves (held, stepped up or stepped down), the transfer size, the polarity of the channel's acknowledge strobe and, on the last channel only, an indirect-source mode. When the transfer engine finishes a beat on a channel, it pulses that channel's `beat_done`. On that clock edge the block moves both addresses by the amount the control byte asks for.

Software or a neighbouring controller reaches the registers through a flat port. One channel index and one register select serve both reads and writes. A write takes effect at the clock edge. The read data always shows the register currently addressed. Each channel's acknowledge output follows its `ack_req` input at the programmed polarity. Settings that cannot be carried out raise a sticky error flag for the channel and stop its addresses from moving on beats.

Top module: `dma_addr_seq`

## Requirements
- R1: After reset, every address register and control byte reads 0 and every `config_error` bit is 0. With `ack_req` low, every `dack` output is 1, because active-low is the reset polarity.
- R2: With mode code 00 in the control byte (source mode in bits [1:0], destination mode in bits [3:2]), a beat leaves that address unchanged.
- R3: With mode code 01, each beat adds the size step to the address. The size field sits in control bits [5:4]. Code 00 adds 1, 01 adds 2, 10 adds 4 and 11 (16-byte block) adds 16.
- R4: With mode code 10, each beat subtracts the size step from the address. Size code 00 subtracts 1, 01 subtracts 2 and 10 subtracts 4.
- R5: Source and destination move on the same edge, each under its own mode, using 32-bit wrap-around arithmetic.
- R6: Control bit 6 selects indirect-source mode and exists only on channel 3. In that mode the source address moves by +4, -4 or 0 according to the source mode, whatever the size. The destination still uses the size step. On other channels a write to bit 6 is dropped and the bit reads 0.
- R7: Control bit 7 sets the acknowledge polarity on channels 0 and 1. When it is 1, `dack` equals `ack_req`. When it is 0, `dack` is the inverse of `ack_req`.
- R8: On channels 2 and 3, a write to control bit 7 is dropped and the bit reads 0, so their `dack` is always active-low.
- R9: A control byte is illegal when either mode is 11, when the destination mode is 10 with size 11, or when the source mode is 10 with size 11 and indirect mode is off. While a channel's control byte is illegal, beats leave both of its addresses unchanged. Its `config_error` bit goes to 1 on the edge after the illegal byte is in place and stays 1 until reset.
- R10: `reg_sel` 0 selects the source address, 1 the destination address and 2 the control byte (zero-extended). Select 3 reads 0 and a write to it is dropped. A write with `reg_wen` high takes effect at the clock edge. If a write to an address register lands in the same cycle as a beat on that channel, the written value wins.
- R11: A channel whose `beat_done` is low keeps its addresses, whatever beats happen on other channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wen | input | 1 | Register write strobe |
| reg_ch | input | 2 | Channel index for read and write |
| reg_sel | input | 2 | Register select: 0 source, 1 destination, 2 control |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Contents of the addressed register |
| beat_done | input | 4 | Per-channel beat completion pulse |
| ack_req | input | 4 | Per-channel acknowledge request |
| dack | output | 4 | Per-channel acknowledge at the programmed polarity |
| config_error | output | 4 | Per-channel sticky illegal-setting flag |

## Verification
Beats are applied under each size code with the source and destination modes varied independently, including opposite directions on the same channel. This separates a step taken from the size from one taken from the mode, and it exposes a swap between the two address paths. Addresses placed next to the 32-bit boundary check the wrap in both directions. Indirect mode is run with a byte size and with a block size, so a source step of 4 can be told apart from a size-derived step. Illegal settings, polarity writes to channels that lack the bit, and a write that collides with a beat show whether masked bits are dropped, whether the error flag stays set and which update has priority.

// File: rtl/dma_addr_pkg.sv
package dma_addr_pkg;

  typedef enum logic [1:0] {
    AM_HOLD = 2'b00,
    AM_UP   = 2'b01,
    AM_DOWN = 2'b10,
    AM_BAD  = 2'b11
  } addr_mode_e;

  typedef enum logic [1:0] {
    XS_BYTE  = 2'b00,
    XS_HALF  = 2'b01,
    XS_WORD  = 2'b10,
    XS_BLOCK = 2'b11
  } xfer_size_e;

  typedef struct packed {
    logic       ack_high;
    logic       ind_src;
    xfer_size_e size;
    addr_mode_e dst_mode;
    addr_mode_e src_mode;
  } chan_ctrl_t;

  localparam int CTRL_W = $bits(chan_ctrl_t);

  // Step size in bytes for one beat.
  function automatic logic [4:0] size_bytes(xfer_size_e s);
    case (s)
      XS_BYTE:  size_bytes = 5'd1;
      XS_HALF:  size_bytes = 5'd2;
      XS_WORD:  size_bytes = 5'd4;
      default:  size_bytes = 5'd16;
    endcase
  endfunction

  // True when the control byte asks for something that cannot be done.
  function automatic logic ctrl_illegal(chan_ctrl_t c);
    logic blk;
    blk = (c.size == XS_BLOCK);
    ctrl_illegal = (c.src_mode == AM_BAD) || (c.dst_mode == AM_BAD) ||
                   (c.dst_mode == AM_DOWN && blk) ||
                   (c.src_mode == AM_DOWN && blk && !c.ind_src);
  endfunction

endpackage

// File: rtl/dma_step_unit.sv
module dma_step_unit
  import dma_addr_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] src_cur,
  input  logic [AW-1:0] dst_cur,
  input  chan_ctrl_t    ctrl,
  output logic [AW-1:0] src_nxt,
  output logic [AW-1:0] dst_nxt,
  output logic          cfg_bad
);

  localparam int IND_STEP = 4;

  function automatic logic [AW-1:0] move_addr(logic [AW-1:0] a, addr_mode_e m,
                                              logic [AW-1:0] mag);
    case (m)
      AM_UP:   move_addr = a + mag;
      AM_DOWN: move_addr = a - mag;
      default: move_addr = a;
    endcase
  endfunction

  logic [AW-1:0] src_mag;
  logic [AW-1:0] dst_mag;

  always_comb begin
    dst_mag = AW'(size_bytes(ctrl.size));
    src_mag = ctrl.ind_src ? AW'(IND_STEP) : dst_mag;
    src_nxt = move_addr(src_cur, ctrl.src_mode, src_mag);
    dst_nxt = move_addr(dst_cur, ctrl.dst_mode, dst_mag);
    cfg_bad = ctrl_illegal(ctrl);
  end

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_addr_pkg::*;
#(
  parameter int AW      = 32,
  parameter bit HAS_ACK = 1'b1,
  parameter bit HAS_IND = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_src,
  input  logic          wr_dst,
  input  logic          wr_ctrl,
  input  logic [AW-1:0] wdata,
  input  logic          beat,
  input  logic          ack_req,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output chan_ctrl_t    ctrl_out,
  output logic          dack,
  output logic          cfg_err
);

  logic [AW-1:0] src_q, dst_q, src_nxt, dst_nxt;
  chan_ctrl_t    ctrl_q, ctrl_wr;
  logic          err_q;
  logic          cfg_bad;
  logic          beat_apply;

  dma_step_unit #(.AW(AW)) u_step (
    .src_cur (src_q),
    .dst_cur (dst_q),
    .ctrl    (ctrl_q),
    .src_nxt (src_nxt),
    .dst_nxt (dst_nxt),
    .cfg_bad (cfg_bad)
  );

  assign beat_apply = beat && !cfg_bad;

  // Bits absent on this channel are forced to zero on write.
  always_comb begin
    ctrl_wr          = chan_ctrl_t'(wdata[CTRL_W-1:0]);
    ctrl_wr.ack_high = HAS_ACK ? wdata[7] : 1'b0;
    ctrl_wr.ind_src  = HAS_IND ? wdata[6] : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      ctrl_q <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= err_q | cfg_bad;
      if (wr_src)          src_q <= wdata;
      else if (beat_apply) src_q <= src_nxt;
      if (wr_dst)          dst_q <= wdata;
      else if (beat_apply) dst_q <= dst_nxt;
      if (wr_ctrl)         ctrl_q <= ctrl_wr;
    end
  end

  assign src_addr = src_q;
  assign dst_addr = dst_q;
  assign ctrl_out = ctrl_q;
  assign cfg_err  = err_q;
  assign dack     = ctrl_q.ack_high ? ack_req : !ack_req;

  assert_fixed_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_src && ctrl_q.src_mode == AM_HOLD) |=> $stable(src_q));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!beat && !wr_dst) |=> $stable(dst_q));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  assert_illegal_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && cfg_bad && !wr_src) |=> $stable(src_q));

  assert_ind_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_apply && !wr_src && ctrl_q.ind_src && ctrl_q.src_mode == AM_UP)
      |=> src_q == $past(src_q) + AW'(4));

endmodule

// File: rtl/dma_reg_port.sv
module dma_reg_port
  import dma_addr_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 32,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                    reg_wen,
  input  logic [CHW-1:0]          reg_ch,
  input  logic [1:0]              reg_sel,
  input  logic [NCH-1:0][AW-1:0]  src_all,
  input  logic [NCH-1:0][AW-1:0]  dst_all,
  input  logic [NCH-1:0][CTRL_W-1:0] ctrl_all,
  output logic [NCH-1:0]          wr_src_vec,
  output logic [NCH-1:0]          wr_dst_vec,
  output logic [NCH-1:0]          wr_ctrl_vec,
  output logic [AW-1:0]           rdata
);

  localparam logic [1:0] SEL_SRC  = 2'd0;
  localparam logic [1:0] SEL_DST  = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

  for (genvar i = 0; i < NCH; i++) begin : g_dec
    logic hit;
    assign hit            = reg_wen && (reg_ch == CHW'(i));
    assign wr_src_vec[i]  = hit && (reg_sel == SEL_SRC);
    assign wr_dst_vec[i]  = hit && (reg_sel == SEL_DST);
    assign wr_ctrl_vec[i] = hit && (reg_sel == SEL_CTRL);
  end

  always_comb begin
    rdata = '0;
    case (reg_sel)
      SEL_SRC:  rdata = src_all[reg_ch];
      SEL_DST:  rdata = dst_all[reg_ch];
      SEL_CTRL: rdata = AW'(ctrl_all[reg_ch]);
      default:  rdata = '0;
    endcase
  end

  always_comb begin
    assert_one_target_R10: assert ($onehot0({wr_src_vec, wr_dst_vec, wr_ctrl_vec}));
  end

endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq
  import dma_addr_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int AW        = 32,
  parameter int ACK_CHANS = 2,
  parameter int IND_CHAN  = 3,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wen,
  input  logic [CHW-1:0] reg_ch,
  input  logic [1:0]     reg_sel,
  input  logic [AW-1:0]  reg_wdata,
  output logic [AW-1:0]  reg_rdata,
  input  logic [NCH-1:0] beat_done,
  input  logic [NCH-1:0] ack_req,
  output logic [NCH-1:0] dack,
  output logic [NCH-1:0] config_error
);

  logic [NCH-1:0][AW-1:0]     src_all, dst_all;
  logic [NCH-1:0][CTRL_W-1:0] ctrl_all;
  logic [NCH-1:0]             wr_src_vec, wr_dst_vec, wr_ctrl_vec;

  dma_reg_port #(.NCH(NCH), .AW(AW)) u_port (
    .reg_wen     (reg_wen),
    .reg_ch      (reg_ch),
    .reg_sel     (reg_sel),
    .src_all     (src_all),
    .dst_all     (dst_all),
    .ctrl_all    (ctrl_all),
    .wr_src_vec  (wr_src_vec),
    .wr_dst_vec  (wr_dst_vec),
    .wr_ctrl_vec (wr_ctrl_vec),
    .rdata       (reg_rdata)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    chan_ctrl_t ctrl_i;
    dma_chan_regs #(
      .AW      (AW),
      .HAS_ACK (i < ACK_CHANS),
      .HAS_IND (i == IND_CHAN)
    ) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_src   (wr_src_vec[i]),
      .wr_dst   (wr_dst_vec[i]),
      .wr_ctrl  (wr_ctrl_vec[i]),
      .wdata    (reg_wdata),
      .beat     (beat_done[i]),
      .ack_req  (ack_req[i]),
      .src_addr (src_all[i]),
      .dst_addr (dst_all[i]),
      .ctrl_out (ctrl_i),
      .dack     (dack[i]),
      .cfg_err  (config_error[i])
    );
    assign ctrl_all[i] = ctrl_i;

    if (i >= ACK_CHANS) begin : g_noack
      assert_low_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req[i] |=> (dack[i] == !ack_req[i]));
    end
  end

endmodule

// File: tb/dma_addr_seq_bench.sv
`timescale 1ns/1ps
module dma_addr_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wen = 1'b0;
  logic [1:0]  reg_ch = '0;
  logic [1:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  beat_done = '0;
  logic [3:0]  ack_req = '0;
  logic [3:0]  dack;
  logic [3:0]  config_error;

  always #2 clk = ~clk;

  dma_addr_seq u_dma_addr_seq (
    .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_ch(reg_ch),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .beat_done(beat_done), .ack_req(ack_req), .dack(dack),
    .config_error(config_error)
  );

  // Reference state
  logic [31:0] m_src [4];
  logic [31:0] m_dst [4];
  logic [7:0]  m_ctl [4];
  logic        m_err [4];
  int sz_tab [4] = '{1, 2, 4, 16};

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;
  string cur_req = "R1";

  function automatic bit m_bad(logic [7:0] c);
    bit blk = (c[5:4] == 2'b11);
    return (c[1:0] == 2'b11) || (c[3:2] == 2'b11) ||
           (c[3:2] == 2'b10 && blk) ||
           (c[1:0] == 2'b10 && blk && !c[6]);
  endfunction

  function automatic logic [31:0] m_move(logic [31:0] a, logic [1:0] m, int mag);
    if (m == 2'b01) return a + 32'(mag);
    if (m == 2'b10) return a - 32'(mag);
    return a;
  endfunction

  task automatic model_edge();
    for (int c = 0; c < 4; c++) begin
      logic [31:0] ns, nd;
      logic [7:0]  k;
      bit bad;
      k = m_ctl[c];
      bad = m_bad(k);
      ns = m_src[c];
      nd = m_dst[c];
      if (beat_done[c] && !bad) begin
        ns = m_move(ns, k[1:0], k[6] ? 4 : sz_tab[k[5:4]]);
        nd = m_move(nd, k[3:2], sz_tab[k[5:4]]);
      end
      if (bad) m_err[c] = 1'b1;
      if (reg_wen && reg_ch == c) begin
        if (reg_sel == 2'd0) ns = reg_wdata;
        if (reg_sel == 2'd1) nd = reg_wdata;
        if (reg_sel == 2'd2) begin
          k = reg_wdata[7:0];
          if (c > 1) k[7] = 1'b0;
          if (c != 3) k[6] = 1'b0;
          m_ctl[c] = k;
        end
      end
      m_src[c] = ns;
      m_dst[c] = nd;
    end
  endtask

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare();
    logic [31:0] er;
    logic [3:0] ed, ee;
    case (reg_sel)
      2'd0: er = m_src[reg_ch];
      2'd1: er = m_dst[reg_ch];
      2'd2: er = {24'd0, m_ctl[reg_ch]};
      default: er = '0;
    endcase
    for (int c = 0; c < 4; c++) begin
      ed[c] = m_ctl[c][7] ? ack_req[c] : !ack_req[c];
      ee[c] = m_err[c];
    end
    check($sformatf("rdata ch%0d sel%0d", reg_ch, reg_sel), reg_rdata, er);
    check("dack", {28'd0, dack}, {28'd0, ed});
    check("config_error", {28'd0, config_error}, {28'd0, ee});
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    #1;
    compare();
  endtask

  task automatic wr(int ch, int sel, logic [31:0] d);
    reg_wen = 1'b1; reg_ch = 2'(ch); reg_sel = 2'(sel); reg_wdata = d;
    tick();
    reg_wen = 1'b0;
  endtask

  task automatic beats(logic [3:0] mask, int n);
    beat_done = mask;
    for (int i = 0; i < n; i++) tick();
    beat_done = '0;
  endtask

  task automatic sweep();
    for (int c = 0; c < 4; c++)
      for (int s = 0; s < 4; s++) begin
        reg_ch = 2'(c); reg_sel = 2'(s);
        tick();
      end
  endtask

  // ctrl byte: [7] ack_high, [6] indirect, [5:4] size, [3:2] dst mode, [1:0] src mode
  function automatic logic [31:0] cb(int ah, int ind, int sz, int dm, int sm);
    return {24'd0, 1'(ah), 1'(ind), 2'(sz), 2'(dm), 2'(sm)};
  endfunction

  initial begin
    for (int c = 0; c < 4; c++) begin
      m_src[c] = '0; m_dst[c] = '0; m_ctl[c] = '0; m_err[c] = 1'b0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    cur_req = "R1"; sweep();

    cur_req = "R10";
    wr(0, 0, 32'h1000_0000); wr(0, 1, 32'h2000_0000);
    wr(0, 3, 32'hDEAD_BEEF); sweep();

    cur_req = "R2";
    beats(4'b0001, 3); sweep();

    cur_req = "R3";
    for (int sz = 0; sz < 4; sz++) begin
      wr(0, 2, cb(0, 0, sz, 1, 1));
      beats(4'b0001, 3);
      reg_ch = 0; reg_sel = 0; tick(); reg_sel = 1; tick();
    end

    cur_req = "R4";
    for (int sz = 0; sz < 3; sz++) begin
      wr(1, 2, cb(0, 0, sz, 2, 2));
      wr(1, 0, 32'h0000_0100); wr(1, 1, 32'h0000_0200);
      beats(4'b0010, 2);
      reg_ch = 1; reg_sel = 0; tick(); reg_sel = 1; tick();
    end

    cur_req = "R5";
    wr(2, 0, 32'hFFFF_FFFE); wr(2, 1, 32'h0000_0001);
    wr(2, 2, cb(0, 0, 2, 2, 1));
    beats(4'b0100, 1);
    wr(2, 2, cb(0, 0, 1, 2, 1));
    beats(4'b0100, 1);
    sweep();

    cur_req = "R11";
    beats(4'b0100, 4); sweep();

    cur_req = "R6";
    wr(3, 0, 32'h0000_4000); wr(3, 1, 32'h0000_8000);
    wr(3, 2, cb(0, 1, 0, 1, 1));
    beats(4'b1000, 3);
    wr(3, 2, cb(0, 1, 3, 1, 2));
    beats(4'b1000, 2);
    wr(1, 2, cb(0, 1, 0, 0, 0));
    sweep();

    cur_req = "R7";
    wr(0, 2, cb(1, 0, 0, 0, 0));
    ack_req = 4'b1111; tick(); ack_req = 4'b0000; tick();
    wr(0, 2, cb(0, 0, 0, 0, 0));
    ack_req = 4'b0001; tick(); ack_req = 4'b0000; tick();

    cur_req = "R8";
    wr(2, 2, cb(1, 0, 0, 0, 0)); wr(3, 2, cb(1, 0, 0, 0, 0));
    reg_ch = 2; reg_sel = 2; tick();
    ack_req = 4'b1100; tick(); tick(); ack_req = 4'b0000; tick();

    cur_req = "R9";
    wr(1, 0, 32'h0000_0500); wr(1, 1, 32'h0000_0600);
    wr(1, 2, cb(0, 0, 0, 1, 3));
    beats(4'b0010, 3); sweep();
    wr(0, 2, cb(0, 0, 3, 2, 1));
    beats(4'b0001, 2);
    wr(1, 2, cb(0, 0, 1, 1, 1));
    beats(4'b0010, 2); sweep();

    cur_req = "R10";
    wr(2, 2, cb(0, 0, 2, 1, 1));
    beat_done = 4'b0100;
    wr(2, 0, 32'h0000_0ABC);
    beat_done = 4'b0000;
    sweep();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule